// File: doc/BRIEF.md
# Receive Buffer Flow-Status Generator

This block sits beside a shared receive buffer and turns its occupancy into two kinds of flow information. Towards the local reader it raises a data-available flag, either purely from a low-water comparison on the fill level or also whenever at least one complete packet end is stored. To make that possible it keeps its own count of stored packet ends, which moves with end-of-packet writes and reads.

Towards the far transmitter it produces a 2-bit flow-control code for every slot of a status calendar. At each slot strobe the block captures a new code and holds it until the next strobe. The code comes from one of three sources. The first compares the fill level with almost-empty and almost-full thresholds. The second passes through a per-port value supplied by user logic. The third is a protective blend that never grants more data than the buffer level allows.

Top module: `rxstat_gen`

## Requirements
- R1: `data_avail` is high whenever `fill_level` is strictly greater than `thr_low`, whatever the value of `eop_dav_en`.
- R2: With `eop_dav_en` = 1, `data_avail` is high whenever the stored end-of-packet count is non-zero, even if `fill_level` <= `thr_low`.
- R3: With `eop_dav_en` = 0, the stored end-of-packet count has no effect: `data_avail` is high only when `fill_level` > `thr_low`.
- R4: The stored end-of-packet count starts at 0. It rises by one the cycle after an `eop_wr` pulse, falls by one the cycle after an `eop_rd` pulse, and stays unchanged when both are high together. A read at zero leaves it at zero, and the count saturates at its maximum.
- R5: The status codes are 2'b00 starving, 2'b01 hungry and 2'b10 satisfied. In fill mode (`src_mode` = 2'b00) the code is satisfied when `fill_level` >= `thr_af`, otherwise starving when `fill_level` < `thr_ae`, otherwise hungry.
- R6: In user mode (`src_mode` = 2'b01) the code is the 2-bit field `user_status[2*p+1:2*p]` of the strobed port p = `slot_port`. A user value of 2'b11 is sent as satisfied (2'b10).
- R7: In safe mode (`src_mode` = 2'b10, and also 2'b11) the code is the numerically larger of the user code (after the R6 mapping) and the fill-mode code.
- R8: `slot_status` is loaded on the clock edge where `slot_strobe` is high and is held at all other edges. Reset sets it to satisfied (2'b10).
- R9: `slot_status` never carries 2'b11.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | LVL_W | Current buffer occupancy |
| thr_low | input | LVL_W | Low-water threshold for data-available |
| thr_ae | input | LVL_W | Almost-empty threshold |
| thr_af | input | LVL_W | Almost-full threshold |
| eop_wr | input | 1 | A packet end was written into the buffer |
| eop_rd | input | 1 | A packet end was read from the buffer |
| eop_dav_en | input | 1 | Let stored packet ends raise data-available |
| slot_strobe | input | 1 | Capture status for a new calendar slot |
| slot_port | input | PORT_W | Port that owns the strobed slot |
| user_status | input | 2*NPORTS | User-supplied 2-bit code per port |
| src_mode | input | 2 | Status source: 00 fill, 01 user, 10/11 safe |
| data_avail | output | 1 | Data is available for the reader |
| slot_status | output | 2 | Flow-control code of the current slot |

## Verification
The fill comparison is tried at the level one below and exactly at each threshold. These cases show whether each bound is inclusive or exclusive and whether almost-full takes priority. Data-available is driven once with the level above the low mark and the counter empty, and once with the level below it and a packet end stored, each with the packet-end option on and off, so that the two sources of the flag can be told apart. The counter is driven with a lone write, a simultaneous write and read, a lone read and a read at zero followed by a write, which exposes wrap-around. The source modes are tried with user and fill codes that disagree in both directions, including the reserved user code, so that pass-through, blending and masking give different results.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10
    } flow_st_e;

    typedef enum logic [1:0] {
        SRC_FILL = 2'b00,
        SRC_USER = 2'b01,
        SRC_SAFE = 2'b10,
        SRC_ALT  = 2'b11
    } src_mode_e;

    // Map threshold comparison flags onto a flow code; almost-full wins.
    function automatic flow_st_e level_code(input logic at_af, input logic below_ae);
        if (at_af)         return ST_SATISFIED;
        else if (below_ae) return ST_STARVING;
        else               return ST_HUNGRY;
    endfunction

    // Reserved user code is treated as the most restrictive legal one.
    function automatic flow_st_e clean_user(input logic [1:0] raw);
        if (raw == 2'b11) return ST_SATISFIED;
        else              return flow_st_e'(raw);
    endfunction

    function automatic flow_st_e stricter(input flow_st_e a, input flow_st_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxstat_eop_count.sv
module rxstat_eop_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eop_wr,
    input  logic             eop_rd,
    output logic [CNT_W-1:0] eop_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            eop_cnt <= '0;
        end else if (eop_wr && !eop_rd && eop_cnt != CNT_MAX) begin
            eop_cnt <= eop_cnt + 1'b1;
        end else if (eop_rd && !eop_wr && eop_cnt != '0) begin
            eop_cnt <= eop_cnt - 1'b1;
        end
    end

    a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
        (eop_wr && !eop_rd && eop_cnt != CNT_MAX) |=> eop_cnt == $past(eop_cnt) + 1'b1);
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (eop_rd && !eop_wr && eop_cnt != '0) |=> eop_cnt == $past(eop_cnt) - 1'b1);
    a_r4_count_both: assert property (@(posedge clk) disable iff (rst)
        (eop_rd && eop_wr) |=> $stable(eop_cnt));
endmodule

// File: rtl/rxstat_slot_status.sv
module rxstat_slot_status
    import rxstat_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int NPORTS = 4,
    parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LVL_W-1:0]    fill_level,
    input  logic [LVL_W-1:0]    thr_ae,
    input  logic [LVL_W-1:0]    thr_af,
    input  logic                slot_strobe,
    input  logic [PORT_W-1:0]   slot_port,
    input  logic [2*NPORTS-1:0] user_status,
    input  logic [1:0]          src_mode,
    output logic [1:0]          slot_status
);
    flow_st_e  fill_st;
    flow_st_e  user_st;
    flow_st_e  next_st;
    flow_st_e  st_q;
    src_mode_e mode;
    logic [1:0] user_sel [NPORTS];

    for (genvar p = 0; p < NPORTS; p++) begin : g_user
        assign user_sel[p] = user_status[2*p +: 2];
    end

    assign mode    = src_mode_e'(src_mode);
    assign fill_st = level_code(fill_level >= thr_af, fill_level < thr_ae);
    assign user_st = clean_user(user_sel[slot_port]);

    always_comb begin
        unique case (mode)
            SRC_FILL: next_st = fill_st;
            SRC_USER: next_st = user_st;
            default:  next_st = stricter(user_st, fill_st);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              st_q <= ST_SATISFIED;
        else if (slot_strobe) st_q <= next_st;
    end

    assign slot_status = st_q;

    a_r9_no_reserved: assert property (@(posedge clk) disable iff (rst)
        slot_status != 2'b11);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !slot_strobe |=> $stable(slot_status));
    a_r7_never_looser: assert property (@(posedge clk) disable iff (rst)
        (slot_strobe && src_mode[1]) |=> slot_status >= $past(fill_st));
    a_r6_user_pass: assert property (@(posedge clk) disable iff (rst)
        (slot_strobe && src_mode == 2'b01) |=> slot_status == $past(user_st));
endmodule

// File: rtl/rxstat_gen.sv
module rxstat_gen
    import rxstat_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int CNT_W  = 6,
    parameter int NPORTS = 4,
    parameter int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LVL_W-1:0]    fill_level,
    input  logic [LVL_W-1:0]    thr_low,
    input  logic [LVL_W-1:0]    thr_ae,
    input  logic [LVL_W-1:0]    thr_af,
    input  logic                eop_wr,
    input  logic                eop_rd,
    input  logic                eop_dav_en,
    input  logic                slot_strobe,
    input  logic [PORT_W-1:0]   slot_port,
    input  logic [2*NPORTS-1:0] user_status,
    input  logic [1:0]          src_mode,
    output logic                data_avail,
    output logic [1:0]          slot_status
);
    logic [CNT_W-1:0] eop_cnt;
    logic             above_low;

    rxstat_eop_count #(.CNT_W(CNT_W)) u_eop (
        .clk     (clk),
        .rst     (rst),
        .eop_wr  (eop_wr),
        .eop_rd  (eop_rd),
        .eop_cnt (eop_cnt)
    );

    rxstat_slot_status #(.LVL_W(LVL_W), .NPORTS(NPORTS), .PORT_W(PORT_W)) u_slot (
        .clk         (clk),
        .rst         (rst),
        .fill_level  (fill_level),
        .thr_ae      (thr_ae),
        .thr_af      (thr_af),
        .slot_strobe (slot_strobe),
        .slot_port   (slot_port),
        .user_status (user_status),
        .src_mode    (src_mode),
        .slot_status (slot_status)
    );

    assign above_low  = fill_level > thr_low;
    assign data_avail = above_low || (eop_dav_en && eop_cnt != '0);

    a_r2_stored_eop: assert property (@(posedge clk) disable iff (rst)
        (eop_dav_en && eop_cnt != '0) |-> data_avail);
    a_r3_no_eop_mode: assert property (@(posedge clk) disable iff (rst)
        (!eop_dav_en && fill_level <= thr_low) |-> !data_avail);
endmodule

// File: tb/rxstat_gen_tb_top.sv
module rxstat_gen_tb_top;
    localparam int LVL_W = 10;
    localparam int NPORTS = 4;
    localparam int PORT_W = 2;

    logic clk = 1'b0;
    logic rst;
    logic [LVL_W-1:0] fill_level, thr_low, thr_ae, thr_af;
    logic eop_wr, eop_rd, eop_dav_en, slot_strobe;
    logic [PORT_W-1:0] slot_port;
    logic [2*NPORTS-1:0] user_status;
    logic [1:0] src_mode;
    logic data_avail;
    logic [1:0] slot_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxstat_gen #(.LVL_W(LVL_W), .CNT_W(6), .NPORTS(NPORTS), .PORT_W(PORT_W)) dut_i (
        .clk(clk), .rst(rst), .fill_level(fill_level), .thr_low(thr_low),
        .thr_ae(thr_ae), .thr_af(thr_af), .eop_wr(eop_wr), .eop_rd(eop_rd),
        .eop_dav_en(eop_dav_en), .slot_strobe(slot_strobe), .slot_port(slot_port),
        .user_status(user_status), .src_mode(src_mode),
        .data_avail(data_avail), .slot_status(slot_status)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_eop(input bit wr, input bit rd);
        @(negedge clk); eop_wr = wr; eop_rd = rd;
        @(negedge clk); eop_wr = 1'b0; eop_rd = 1'b0;
    endtask

    task automatic strobe(input int port);
        @(negedge clk); slot_strobe = 1'b1; slot_port = PORT_W'(port);
        @(negedge clk); slot_strobe = 1'b0;
    endtask

    task automatic t_reset;
        check("R8 reset status", slot_status, 2);
        check("R4 reset count via R2", data_avail, 0);
    endtask

    task automatic t_threshold;
        eop_dav_en = 1'b0;
        fill_level = 8; #1; check("R1 level equal low", data_avail, 0);
        fill_level = 9; #1; check("R1 level above low off", data_avail, 1);
        eop_dav_en = 1'b1; #1; check("R1 level above low on", data_avail, 1);
        fill_level = 0; #1;
    endtask

    task automatic t_eop_count;
        eop_dav_en = 1'b1; fill_level = 0;
        pulse_eop(1, 0); check("R2 one stored eop", data_avail, 1);
        eop_dav_en = 1'b0; #1; check("R3 stored eop ignored", data_avail, 0);
        eop_dav_en = 1'b1;
        pulse_eop(1, 1); check("R4 wr+rd keeps count", data_avail, 1);
        pulse_eop(0, 1); check("R4 read to zero", data_avail, 0);
        pulse_eop(0, 1); check("R4 read at zero", data_avail, 0);
        pulse_eop(1, 0); check("R4 no wrap after read at zero", data_avail, 1);
        pulse_eop(1, 0); pulse_eop(0, 1);
        check("R4 two writes one read", data_avail, 1);
        pulse_eop(0, 1); check("R4 drained", data_avail, 0);
    endtask

    task automatic t_fill_status;
        src_mode = 2'b00;
        fill_level = 15; strobe(0); check("R5 below ae", slot_status, 0);
        fill_level = 16; strobe(0); check("R5 at ae", slot_status, 1);
        fill_level = 47; strobe(0); check("R5 below af", slot_status, 1);
        fill_level = 48; strobe(0); check("R5 at af", slot_status, 2);
        thr_ae = 60; strobe(0); check("R5 af priority", slot_status, 2);
        thr_ae = 16;
    endtask

    task automatic t_user;
        src_mode = 2'b01; fill_level = 0;
        user_status = {2'b11, 2'b10, 2'b01, 2'b00};
        strobe(2); check("R6 user port2", slot_status, 2);
        strobe(1); check("R6 user port1", slot_status, 1);
        strobe(0); check("R6 user port0", slot_status, 0);
        strobe(3); check("R6 reserved mapped R9", slot_status, 2);
    endtask

    task automatic t_safe;
        user_status = {2'b11, 2'b10, 2'b01, 2'b00};
        src_mode = 2'b10;
        fill_level = 30; strobe(0); check("R7 fill hungry user starving", slot_status, 1);
        fill_level = 0;  strobe(1); check("R7 fill starving user hungry", slot_status, 1);
        fill_level = 50; strobe(1); check("R7 fill full user hungry", slot_status, 2);
        fill_level = 0;  strobe(0); check("R7 both starving", slot_status, 0);
        src_mode = 2'b11;
        fill_level = 30; strobe(3); check("R7 alt mode reserved user", slot_status, 2);
    endtask

    task automatic t_hold;
        src_mode = 2'b00; fill_level = 0; strobe(0);
        check("R8 captured starving", slot_status, 0);
        fill_level = 50;
        repeat (3) @(negedge clk);
        check("R8 held without strobe", slot_status, 0);
        strobe(0); check("R8 updated on strobe", slot_status, 2);
    endtask

    initial begin
        rst = 1'b1; fill_level = 0; thr_low = 8; thr_ae = 16; thr_af = 48;
        eop_wr = 0; eop_rd = 0; eop_dav_en = 1; slot_strobe = 0; slot_port = 0;
        user_status = '0; src_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_eop_count();
        t_fill_status();
        t_user();
        t_safe();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule